// File: doc/BRIEF.md
# Banked Memory Mode Mapper

The mapper sits between an 8-bit processor's 16-bit address bus and two memory domains. One domain is a 512 KB local RAM, split into eight 64 KB blocks. The other is the host mainboard. For every memory cycle the mapper picks one of three results for the address: the host, a local block, or nothing at all. It drives a host select, a local chip enable and a 19-bit local address. The local address is the 3-bit block number followed by the 16 CPU address bits.

The active mapping is set by a configuration byte that the CPU writes to I/O port 0x60. Bits 4:0 hold the mode code and bit 5 enables I/O stretching. When stretching is enabled, the mapper raises a single-cycle wait request at the start of any I/O cycle addressed to ports 0xE0 to 0xFF. The mode decode is purely combinational. The only state is the configuration latch and one flop used to detect the start of an I/O cycle.

Top module: `mm_bank_mapper`

## Requirements
- R1: After synchronous reset the configuration is 0x00. Every memory cycle goes to the host, and no wait request is raised.
- R2: An I/O write (io_req=1, io_we=1) to port 0x60 stores io_wdata[5:0] at the next clock edge. io_wdata[7:6] are ignored. Writes to other ports, and I/O reads of port 0x60, leave the configuration unchanged.
- R3: Mode 0, and every code not listed in R4 to R9, sends all addresses to the host.
- R4: Mode 1 sends 0xE800 to 0xEFFF to local block 0 and every other address to the host.
- R5: Mode 2 and mode 0x17 send the whole 0x0000 to 0xFFFF range to local block 0.
- R6: Modes 3, 4 and 5 send 0xF000 to 0xFFFF to local blocks 1, 2 and 3 respectively, and 0x0000 to 0xEFFF to local block 0.
- R7: Mode 0x0A sends 0x0000 to 0x0FFF to local block 6, 0x1000 to 0xCFFF to local block 0, and 0xD000 to 0xFFFF to the host.
- R8: Mode 0x0D sends 0x0000 to 0xCFFF to local block 0. For 0xD000 to 0xFFFF both host_sel and local_en stay low.
- R9: Mode 0x16 sends all addresses to the host.
- R10: Whenever local_en is high, local_addr equals {block[2:0], cpu_addr[15:0]}.
- R11: host_sel and local_en are never high together, and both are low while mem_req is low.
- R12: When configuration bit 5 is set, wait_req is high in the first cycle of an I/O cycle whose port lies in 0xE0 to 0xFF. It is never high for other ports, and never high while bit 5 is clear.
- R13: wait_req lasts exactly one cycle, even when io_req is held for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | An I/O cycle is in progress |
| io_we | input | 1 | The I/O cycle is a write |
| io_port | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_req | input | 1 | A memory cycle is in progress |
| cpu_addr | input | 16 | CPU memory address |
| host_sel | output | 1 | Route the cycle to the host mainboard |
| local_en | output | 1 | Chip enable for local RAM |
| local_addr | output | 19 | Local RAM address: {block, cpu_addr} |
| wait_req | output | 1 | Single-cycle I/O wait request |

## Verification
Each of the 32 mode codes is written in turn, with junk placed in bits 7:6. The bench then sweeps the address space in 1 KB steps and also hits every window edge (0x0FFF/0x1000, 0xCFFF/0xD000, 0xE7FF/0xE800, 0xEFFF/0xF000, 0xFFFF). This separates the listed modes from the fallback codes, and exposes any off-by-one window boundary or wrong block number. The port sweep covers all 256 ports, once with stretching enabled and once with it disabled, which pins down the 0xDF/0xE0 edge and the gating by bit 5. Three further cases each check one thing: a held I/O cycle shows the wait lasting a single cycle, a write to a neighbouring port and a read of the latch port show that neither changes the configuration, and a pass with mem_req low shows that both outputs stay idle.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int ADDR_W  = 16;
    localparam int BLK_W   = 3;
    localparam int LADDR_W = ADDR_W + BLK_W;
    localparam int MODE_W  = 5;

    typedef enum logic [MODE_W-1:0] {
        MM_HOST     = 5'h00,
        MM_BOOT     = 5'h01,
        MM_LOC0     = 5'h02,
        MM_HI1      = 5'h03,
        MM_HI2      = 5'h04,
        MM_HI3      = 5'h05,
        MM_SPLIT    = 5'h0A,
        MM_GAP      = 5'h0D,
        MM_HOSTONLY = 5'h16,
        MM_LOCONLY  = 5'h17
    } mm_mode_e;

    typedef struct packed {
        logic              wait_en;
        logic [MODE_W-1:0] mode;
    } mm_cfg_t;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_HOST  = 2'd1,
        TGT_LOCAL = 2'd2
    } mm_tgt_e;

    typedef struct packed {
        mm_tgt_e           tgt;
        logic [BLK_W-1:0]  blk;
    } mm_route_t;

    function automatic mm_route_t mk_route(mm_tgt_e t, logic [BLK_W-1:0] b);
        mm_route_t r;
        r.tgt = t;
        r.blk = b;
        return r;
    endfunction
endpackage

// File: rtl/mm_cfg_latch.sv
module mm_cfg_latch
    import mm_pkg::*;
#(
    parameter logic [7:0] CFG_PORT = 8'h60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_req,
    input  logic       io_we,
    input  logic [7:0] io_port,
    input  logic [7:0] io_wdata,
    output mm_cfg_t    cfg_q
);
    localparam int CFG_W = MODE_W + 1;

    logic hit;
    assign hit = io_req && io_we && (io_port == CFG_PORT);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (hit)
            cfg_q <= mm_cfg_t'(io_wdata[CFG_W-1:0]);
    end
endmodule

// File: rtl/mm_window_decode.sv
module mm_window_decode
    import mm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] addr,
    output mm_route_t         route
);
    logic [3:0] page4k;
    logic       in_low4k, in_top4k, in_hi_io, in_boot;

    assign page4k   = addr[ADDR_W-1 -: 4];
    assign in_low4k = (page4k == 4'h0);
    assign in_top4k = (page4k == 4'hF);
    assign in_hi_io = (page4k >= 4'hD);
    assign in_boot  = (addr[ADDR_W-1 -: 5] == 5'b11101);

    always_comb begin
        route = mk_route(TGT_HOST, '0);
        case (mode)
            MM_BOOT:
                if (in_boot) route = mk_route(TGT_LOCAL, 3'd0);
            MM_LOC0, MM_LOCONLY:
                route = mk_route(TGT_LOCAL, 3'd0);
            MM_HI1, MM_HI2, MM_HI3:
                if (in_top4k)
                    route = mk_route(TGT_LOCAL, BLK_W'(mode - MM_LOC0));
                else
                    route = mk_route(TGT_LOCAL, 3'd0);
            MM_SPLIT:
                if (in_low4k)      route = mk_route(TGT_LOCAL, 3'd6);
                else if (!in_hi_io) route = mk_route(TGT_LOCAL, 3'd0);
            MM_GAP:
                if (in_hi_io) route = mk_route(TGT_NONE, 3'd0);
                else          route = mk_route(TGT_LOCAL, 3'd0);
            default:
                route = mk_route(TGT_HOST, '0);
        endcase
    end
endmodule

// File: rtl/mm_io_wait.sv
module mm_io_wait #(
    parameter logic [7:0] WAIT_BASE = 8'hE0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wait_en,
    input  logic       io_req,
    input  logic [7:0] io_port,
    output logic       wait_req
);
    logic io_req_q;

    always_ff @(posedge clk) begin
        if (rst) io_req_q <= 1'b0;
        else     io_req_q <= io_req;
    end

    assign wait_req = wait_en && io_req && !io_req_q && (io_port >= WAIT_BASE);
endmodule

// File: rtl/mm_bank_mapper.sv
module mm_bank_mapper
    import mm_pkg::*;
#(
    parameter logic [7:0] CFG_PORT  = 8'h60,
    parameter logic [7:0] WAIT_BASE = 8'hE0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_req,
    input  logic                io_we,
    input  logic [7:0]          io_port,
    input  logic [7:0]          io_wdata,
    input  logic                mem_req,
    input  logic [ADDR_W-1:0]   cpu_addr,
    output logic                host_sel,
    output logic                local_en,
    output logic [LADDR_W-1:0]  local_addr,
    output logic                wait_req
);
    mm_cfg_t   cfg_q;
    mm_route_t route;

    mm_cfg_latch #(.CFG_PORT(CFG_PORT)) u_cfg (
        .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we),
        .io_port(io_port), .io_wdata(io_wdata), .cfg_q(cfg_q)
    );

    mm_window_decode u_dec (
        .mode(cfg_q.mode), .addr(cpu_addr), .route(route)
    );

    mm_io_wait #(.WAIT_BASE(WAIT_BASE)) u_wait (
        .clk(clk), .rst(rst), .wait_en(cfg_q.wait_en), .io_req(io_req),
        .io_port(io_port), .wait_req(wait_req)
    );

    assign host_sel   = mem_req && (route.tgt == TGT_HOST);
    assign local_en   = mem_req && (route.tgt == TGT_LOCAL);
    assign local_addr = {route.blk, cpu_addr};
endmodule

// File: rtl/mm_bank_mapper_chk.sv
module mm_bank_mapper_chk
    import mm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               io_req,
    input logic               io_we,
    input logic [7:0]         io_port,
    input logic [7:0]         io_wdata,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               host_sel,
    input logic               local_en,
    input logic [LADDR_W-1:0] local_addr,
    input logic               wait_req,
    input mm_cfg_t            cfg_q
);
    // R1
    reset_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0));
    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (io_req && io_we && io_port == 8'h60) |=> (cfg_q == mm_cfg_t'($past(io_wdata[5:0]))));
    // R8
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == 5'h0D && cpu_addr[15:12] >= 4'hD) |-> (!host_sel && !local_en));
    // R10
    laddr_chk: assert property (@(posedge clk) disable iff (rst)
        local_en |-> (local_addr[ADDR_W-1:0] == cpu_addr));
    // R11
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_sel && local_en));
    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (!host_sel && !local_en));
    // R12
    wait_port_chk: assert property (@(posedge clk) disable iff (rst)
        wait_req |-> (io_req && io_port[7:5] == 3'b111 && cfg_q.wait_en));
    // R13
    wait_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wait_req |=> !wait_req);
endmodule

bind mm_bank_mapper mm_bank_mapper_chk u_chk (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_port(io_port),
    .io_wdata(io_wdata), .mem_req(mem_req), .cpu_addr(cpu_addr),
    .host_sel(host_sel), .local_en(local_en), .local_addr(local_addr),
    .wait_req(wait_req), .cfg_q(cfg_q)
);

// File: tb/sim_mm_bank_mapper.sv
module sim_mm_bank_mapper;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 1'b0, io_we = 1'b0, mem_req = 1'b0;
    logic [7:0]  io_port = '0, io_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic        host_sel, local_en, wait_req;
    logic [18:0] local_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #HALF clk = ~clk;

    mm_bank_mapper u0 (
        .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_port(io_port),
        .io_wdata(io_wdata), .mem_req(mem_req), .cpu_addr(cpu_addr),
        .host_sel(host_sel), .local_en(local_en), .local_addr(local_addr),
        .wait_req(wait_req)
    );

    // expected {host, local, block} from the requirement text
    function automatic logic [4:0] expect_route(int m, int a);
        int blk;
        if (m == 1) return (a >= 'hE800 && a <= 'hEFFF) ? 5'b01_000 : 5'b10_000;
        if (m == 2 || m == 'h17) return 5'b01_000;
        if (m >= 3 && m <= 5) begin
            blk = (a >= 'hF000) ? m - 2 : 0;
            return {2'b01, 3'(blk)};
        end
        if (m == 'h0A) begin
            if (a < 'h1000) return 5'b01_110;
            if (a < 'hD000) return 5'b01_000;
            return 5'b10_000;
        end
        if (m == 'h0D) return (a < 'hD000) ? 5'b01_000 : 5'b00_000;
        return 5'b10_000; // R3 and R9: host
    endfunction

    function automatic string req_of(int m);
        case (m)
            1: return "R4";
            2, 'h17: return "R5";
            3, 4, 5: return "R6";
            'h0A: return "R7";
            'h0D: return "R8";
            'h16: return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic io_cycle(logic [7:0] p, logic [7:0] d, logic we);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_port = p; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
    endtask

    task automatic probe(int m, int a);
        logic [4:0] e;
        @(negedge clk);
        mem_req = 1'b1; cpu_addr = 16'(a);
        #2;
        e = expect_route(m, a);
        check(req_of(m), {host_sel, local_en, local_addr[18:16]}, e);
        // R10 and R11
        if (local_en) check("R10", local_addr, {e[2:0], 16'(a)});
        check("R11", {31'd0, host_sel & local_en}, 0);
    endtask

    task automatic port_sweep(bit en);
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            io_req = 1'b1; io_port = 8'(p);
            #2;
            check("R12", {31'd0, wait_req}, {31'd0, en && p >= 'hE0});
            @(negedge clk);
            io_req = 1'b0;
        end
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int bounds[10] = '{'h0FFF, 'h1000, 'hCFFF, 'hD000, 'hE7FF,
                           'hE800, 'hEFFF, 'hF000, 'hFFFF, 'h0000};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        probe(0, 'h1234);
        probe(0, 'hE800);
        @(negedge clk); io_req = 1'b1; io_port = 8'hF0; #2;
        check("R1", {31'd0, wait_req}, 0);
        @(negedge clk); io_req = 1'b0;

        // R3..R9 sweep over every mode code, junk in bits 7:6 (R2)
        for (int m = 0; m < 32; m++) begin
            io_cycle(8'h60, 8'(m) | 8'hC0, 1'b1);
            for (int a = 0; a < 65536; a += 'h400) probe(m, a);
            foreach (bounds[i]) probe(m, bounds[i]);
            @(negedge clk); mem_req = 1'b0; #2;
            check("R11", {30'd0, host_sel, local_en}, 0);
        end

        // R2: ignored writes and reads
        io_cycle(8'h60, 8'h02, 1'b1);
        io_cycle(8'h61, 8'h00, 1'b1);
        io_cycle(8'h60, 8'h00, 1'b0);
        probe(2, 'h0100);
        io_cycle(8'h60, 8'h0A, 1'b1);
        probe('h0A, 'h0100);

        // R12: wait enabled then disabled
        io_cycle(8'h60, 8'h20, 1'b1);
        port_sweep(1'b1);
        // R13: held cycle stretches once
        @(negedge clk); io_req = 1'b1; io_port = 8'hE5; #2;
        check("R13", {31'd0, wait_req}, 1);
        @(negedge clk); #2;
        check("R13", {31'd0, wait_req}, 0);
        @(negedge clk); #2;
        check("R13", {31'd0, wait_req}, 0);
        @(negedge clk); io_req = 1'b0;
        io_cycle(8'h60, 8'h00, 1'b1);
        port_sweep(1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule